// File: doc/BRIEF.md
# Branch Target Buffer with Saturating Direction History

This block is a direct-mapped branch target buffer that the fetch stage probes combinationally with the current fetch address. Each entry keeps a valid flag, an address tag, a stored branch target and a 2-bit direction history. When the probe hits and the history says taken, the stored target comes out as the next fetch address in the same cycle. In every other case the next fetch address is the sequential one.

A separate update port carries resolved branches. A taken branch that misses allocates an entry. A hit trains the direction history. A parameter chooses between a last-outcome history and a 2-bit saturating counter. Reacting to a misprediction is left to the surrounding pipeline.

Addresses are byte addresses of 4-byte instructions. The index comes from bits just above the two low bits, and the tag from the bits above the index.

Top module: `branch_target_cache`

## Requirements
- R1: After a synchronous active-high reset every entry is invalid, so every probe misses and predicts not taken.
- R2: On a hit whose history predicts taken, `lk_taken` is 1 and `lk_next_pc` equals the stored target in the same cycle as `fetch_pc`. `lk_taken` is never 1 without `lk_hit`.
- R3: On a miss, or on a hit predicting not taken, `lk_taken` is 0 and `lk_next_pc` is `fetch_pc + 4`. Update addresses are word aligned (`upd_pc[1:0]` = 0).
- R4: An entry hits only when its tag matches. A probe whose index matches a valid entry but whose tag differs misses. A taken update with a new tag replaces the entry at that index.
- R5: A taken update that misses allocates the entry with the new tag and target. In counter mode the history is set to weak taken (2'b10), so the next probe of that address predicts taken.
- R6: A not-taken update that misses changes nothing, and the address still misses afterwards.
- R7: In counter mode (encoding 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken, direction = MSB), a taken update steps the counter up and a not-taken update steps it down. It saturates at 11 and at 00.
- R8: In counter mode, a strongly predicted direction reverses only after two consecutive opposite outcomes.
- R9: In last-outcome mode, the predicted direction of a hitting entry equals the outcome of its most recent update.
- R10: An update takes effect at the clock edge. A probe in the same cycle as an update to the same index sees the contents from before that update.
- R11: A taken update that hits replaces the stored target with `upd_target`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | ADDR_W | Current fetch address to probe |
| lk_hit | output | 1 | Probe matched a valid entry |
| lk_taken | output | 1 | Predicted taken |
| lk_next_pc | output | ADDR_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | ADDR_W | Resolved target address |

## Verification
The bench builds two copies with 32-bit addresses and a 16-entry table. One copy uses the saturating counter and the other uses last-outcome history, and both see the same stimulus. With the small index, two addresses 64 bytes apart alias to one entry, which exercises tag mismatch and replacement. Running both history modes side by side shows how their predictions differ on the same outcome sequence, including saturation at both ends of the counter.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_STRONG_NT = 2'b00;
    localparam ctr_t CTR_WEAK_NT   = 2'b01;
    localparam ctr_t CTR_WEAK_T    = 2'b10;
    localparam ctr_t CTR_STRONG_T  = 2'b11;

    typedef enum logic {
        HIST_LAST = 1'b0,
        HIST_SAT2 = 1'b1
    } hist_mode_e;

    // One saturating step toward the observed outcome.
    function automatic ctr_t sat_step(ctr_t c, logic taken);
        if (taken)
            return (c == CTR_STRONG_T) ? c : ctr_t'(c + 2'd1);
        return (c == CTR_STRONG_NT) ? c : ctr_t'(c - 2'd1);
    endfunction

    function automatic logic ctr_dir(ctr_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/brtgt_hist.sv
module brtgt_hist
    import brtgt_pkg::*;
#(
    parameter hist_mode_e HIST = HIST_SAT2
) (
    input  ctr_t cur,
    input  logic hit,
    input  logic taken,
    output ctr_t nxt
);

    generate
        if (HIST == HIST_SAT2) begin : g_sat
            always_comb begin
                if (hit) nxt = sat_step(cur, taken);
                else     nxt = CTR_WEAK_T;
            end

            always_comb begin
                if (hit === 1'b1 && !$isunknown(cur) && !$isunknown(taken)) begin
                    AST_CTR_ONE_STEP: assert (
                        (taken  && int'(nxt) >= int'(cur) && int'(nxt) - int'(cur) <= 1) ||
                        (!taken && int'(nxt) <= int'(cur) && int'(cur) - int'(nxt) <= 1)
                    ); // R7
                end
            end
        end else begin : g_last
            always_comb nxt = taken ? CTR_STRONG_T : CTR_STRONG_NT;

            always_comb begin
                if (hit === 1'b1 && !$isunknown(taken)) begin
                    AST_LAST_FOLLOWS: assert (ctr_dir(nxt) == taken); // R9
                end
            end
        end
    endgenerate

endmodule

// File: rtl/brtgt_match.sv
module brtgt_match #(
    parameter int TAG_W = 26
) (
    input  logic             valid,
    input  logic [TAG_W-1:0] stored_tag,
    input  logic [TAG_W-1:0] probe_tag,
    output logic             hit
);

    always_comb hit = valid && (stored_tag == probe_tag);

endmodule

// File: rtl/brtgt_store.sv
module brtgt_store
    import brtgt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [ADDR_W-1:0] rd_tgt,
    output ctr_t              rd_ctr,
    input  logic [IDX_W-1:0]  up_idx,
    output logic              up_valid,
    output logic [TAG_W-1:0]  up_tag,
    output ctr_t              up_ctr,
    input  logic              wr_en,
    input  logic              wr_tgt_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_tgt,
    input  ctr_t              wr_ctr
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q [DEPTH];
    logic [ADDR_W-1:0] tgt_q [DEPTH];
    ctr_t              ctr_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst)
            valid_q <= '0;
        else if (wr_en)
            valid_q[up_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            ctr_q[up_idx] <= wr_ctr;
        if (wr_tgt_en) begin
            tag_q[up_idx] <= wr_tag;
            tgt_q[up_idx] <= wr_tgt;
        end
    end

    // Reads see the registered state, i.e. the contents before this cycle's write.
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_tgt   = tgt_q[rd_idx];
        rd_ctr   = ctr_q[rd_idx];
        up_valid = valid_q[up_idx];
        up_tag   = tag_q[up_idx];
        up_ctr   = ctr_q[up_idx];
    end

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_q == '0)); // R1

    AST_NO_SILENT_ALLOC: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(valid_q)); // R6

endmodule

// File: rtl/branch_target_cache.sv
module branch_target_cache
    import brtgt_pkg::*;
#(
    parameter int         ADDR_W = 32,
    parameter int         IDX_W  = 4,
    parameter hist_mode_e HIST   = HIST_SAT2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              lk_hit,
    output logic              lk_taken,
    output logic [ADDR_W-1:0] lk_next_pc,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target
);

    localparam int OFF_W = 2;
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int TAG_LO = IDX_W + OFF_W;

    logic [IDX_W-1:0]  lk_idx, up_idx;
    logic [TAG_W-1:0]  lk_tag, up_tag_in;
    logic              rd_valid, up_valid;
    logic [TAG_W-1:0]  rd_tag, up_tag;
    logic [ADDR_W-1:0] rd_tgt;
    ctr_t              rd_ctr, up_ctr, new_ctr;
    logic              up_hit;
    logic              wr_en, wr_tgt_en;

    always_comb begin
        lk_idx    = fetch_pc[TAG_LO-1:OFF_W];
        lk_tag    = fetch_pc[ADDR_W-1:TAG_LO];
        up_idx    = upd_pc[TAG_LO-1:OFF_W];
        up_tag_in = upd_pc[ADDR_W-1:TAG_LO];
    end

    brtgt_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (lk_idx),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_tgt    (rd_tgt),
        .rd_ctr    (rd_ctr),
        .up_idx    (up_idx),
        .up_valid  (up_valid),
        .up_tag    (up_tag),
        .up_ctr    (up_ctr),
        .wr_en     (wr_en),
        .wr_tgt_en (wr_tgt_en),
        .wr_tag    (up_tag_in),
        .wr_tgt    (upd_target),
        .wr_ctr    (new_ctr)
    );

    brtgt_match #(.TAG_W(TAG_W)) u_lk_match (
        .valid      (rd_valid),
        .stored_tag (rd_tag),
        .probe_tag  (lk_tag),
        .hit        (lk_hit)
    );

    brtgt_match #(.TAG_W(TAG_W)) u_up_match (
        .valid      (up_valid),
        .stored_tag (up_tag),
        .probe_tag  (up_tag_in),
        .hit        (up_hit)
    );

    brtgt_hist #(.HIST(HIST)) u_hist (
        .cur   (up_ctr),
        .hit   (up_hit),
        .taken (upd_taken),
        .nxt   (new_ctr)
    );

    // Prediction path: same cycle as fetch.
    always_comb begin
        lk_taken   = lk_hit && ctr_dir(rd_ctr);
        lk_next_pc = lk_taken ? rd_tgt : fetch_pc + ADDR_W'(4);
    end

    // Training path: hits always train, misses allocate only when taken.
    always_comb begin
        wr_en     = upd_valid && (up_hit || upd_taken);
        wr_tgt_en = upd_valid && upd_taken;
    end

    AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        lk_taken |-> lk_hit); // R2

    AST_UPD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> (upd_pc[OFF_W-1:0] == '0)); // R3

    AST_ALLOC_PREDICTS_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken && !up_hit) |=>
            ((fetch_pc != $past(upd_pc)) || (lk_hit && lk_taken))); // R5

endmodule

// File: tb/tb_branch_target_cache.sv
module tb_branch_target_cache;
    import brtgt_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_pc = '0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;

    logic        hit2, tk2, hit1, tk1;
    logic [31:0] nxt2, nxt1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    branch_target_cache #(.ADDR_W(32), .IDX_W(4), .HIST(HIST_SAT2)) dut (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
        .lk_hit(hit2), .lk_taken(tk2), .lk_next_pc(nxt2),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target)
    );

    branch_target_cache #(.ADDR_W(32), .IDX_W(4), .HIST(HIST_LAST)) dut_lh (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
        .lk_hit(hit1), .lk_taken(tk1), .lk_next_pc(nxt1),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target)
    );

    typedef struct {
        logic [31:0] pc;
        logic        hit;
        logic        t2;
        logic        t1;
        logic [31:0] tgt;
        string       req;
    } exp_t;

    exp_t expq[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: present one cycle of stimulus and queue what the probe must show.
    task automatic step(input logic uv, input logic [31:0] upc, input logic ut,
                        input logic [31:0] utg, input logic [31:0] lpc,
                        input logic eh, input logic e2, input logic e1,
                        input logic [31:0] etgt, input string req);
        exp_t e;
        @(posedge clk);
        #1;
        upd_valid  = uv;
        upd_pc     = upc;
        upd_taken  = ut;
        upd_target = utg;
        fetch_pc   = lpc;
        e.pc = lpc; e.hit = eh; e.t2 = e2; e.t1 = e1; e.tgt = etgt; e.req = req;
        expq.push_back(e);
    endtask

    // Monitor: compare on the falling edge, before the next update lands.
    always @(negedge clk) begin
        if (!rst && expq.size() > 0) begin
            exp_t e;
            logic [31:0] en2, en1;
            e = expq.pop_front();
            en2 = e.t2 ? e.tgt : e.pc + 32'd4;
            en1 = e.t1 ? e.tgt : e.pc + 32'd4;
            chk(hit2 === e.hit, e.req, "hit(sat2)", 32'(hit2), 32'(e.hit));
            chk(tk2  === e.t2,  e.req, "taken(sat2)", 32'(tk2), 32'(e.t2));
            chk(nxt2 === en2,   e.req, "next(sat2)", nxt2, en2);
            chk(hit1 === e.hit, e.req, "hit(last)", 32'(hit1), 32'(e.hit));
            chk(tk1  === e.t1,  e.req, "taken(last)", 32'(tk1), 32'(e.t1));
            chk(nxt1 === en1,   e.req, "next(last)", nxt1, en1);
        end
    end

    localparam logic [31:0] A   = 32'h0000_1000;
    localparam logic [31:0] B   = 32'h0000_1040; // same index as A, other tag
    localparam logic [31:0] C   = 32'h0000_2008;
    localparam logic [31:0] TA  = 32'h0000_2000;
    localparam logic [31:0] TB  = 32'h0000_3000;
    localparam logic [31:0] TC  = 32'h0000_3400;
    localparam logic [31:0] TCC = 32'h0000_0500;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        step(0, 0, 0, 0,   A, 0, 0, 0, 0,  "R1");
        step(1, A, 0, TA,  A, 0, 0, 0, 0,  "R6");
        step(0, 0, 0, 0,   A, 0, 0, 0, 0,  "R6");
        step(1, A, 1, TA,  A, 0, 0, 0, 0,  "R10");
        step(0, 0, 0, 0,   A, 1, 1, 1, TA, "R5");
        step(1, A, 0, 0,   A, 1, 1, 1, TA, "R10");
        step(0, 0, 0, 0,   A, 1, 0, 0, TA, "R9");
        step(1, A, 1, TA,  A, 1, 0, 0, TA, "R3");
        step(1, A, 1, TA,  A, 1, 1, 1, TA, "R7");
        step(1, A, 1, TA,  A, 1, 1, 1, TA, "R7");
        step(1, A, 1, TA,  A, 1, 1, 1, TA, "R7");
        step(1, A, 0, 0,   A, 1, 1, 1, TA, "R7");  // upper saturation held
        step(1, A, 0, 0,   A, 1, 1, 0, TA, "R8");  // one miss keeps taken
        step(0, 0, 0, 0,   A, 1, 0, 0, TA, "R8");  // second miss reverses
        step(1, A, 0, 0,   A, 1, 0, 0, TA, "R7");
        step(1, A, 0, 0,   A, 1, 0, 0, TA, "R7");
        step(1, A, 1, TA,  A, 1, 0, 0, TA, "R7");
        step(0, 0, 0, 0,   A, 1, 0, 1, TA, "R7");  // lower saturation held
        step(0, 0, 0, 0,   B, 0, 0, 0, 0,  "R4");
        step(1, B, 1, TB,  A, 1, 0, 1, TA, "R4");
        step(0, 0, 0, 0,   A, 0, 0, 0, 0,  "R4");
        step(0, 0, 0, 0,   B, 1, 1, 1, TB, "R5");
        step(1, B, 1, TC,  B, 1, 1, 1, TB, "R11");
        step(0, 0, 0, 0,   B, 1, 1, 1, TC, "R11");
        step(1, C, 1, TCC, B, 1, 1, 1, TC, "R2");
        step(0, 0, 0, 0,   C, 1, 1, 1, TCC, "R2");
        step(0, 0, 0, 0,   B, 1, 1, 1, TC, "R4");
        step(0, 0, 0, 0,   32'h0000_4000, 0, 0, 0, 0, "R3");
        repeat (2) @(posedge clk);
        if (expq.size() != 0) chk(1'b0, "R1", "queue drained", 32'(expq.size()), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=%h expected=%h", 32'(expq.size()), 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule